// File: doc/BRIEF.md
# TAP Chain Length Probe

This block is a host-side sequencer that measures how many test-access-port devices sit on a JTAG daisy chain. It generates the test clock by dividing the system clock. It drives the shared mode-select and data-in lines and samples the data returned from the far end of the chain. A single start pulse launches one complete probe. When the result is ready, the block pulses done for one system clock and holds the device count and an error flag until the next probe.

A probe runs in fixed steps. The block first holds mode-select high for several test clocks, which forces every device into its reset state whatever state it was in. It then walks all devices together to the instruction-shift state with the mode-select sequence 0,1,1,0,0. There it shifts in an all-ones instruction long enough to cover the largest supported chain, so every device selects its single-bit bypass register. Next it walks to the data-shift state with 1,1,0,0 and pushes zeros through the data path. After that it sends a single 1 as the marker. The number of test clocks until the marker returns is the device count. The probe ends by walking all devices to Run-Test/Idle with 1,1,0.

Top module: `tap_chain_probe`

## Requirements
- R1: During and right after reset, tck_o, tdi_o, done_o, count_o and error_o are 0 and tms_o is 1.
- R2: tck_o stays low while no probe is running. During a probe its period is CLK_DIV system clocks, of which CLK_DIV/2 are high.
- R3: The first RST_CYC test clocks of every probe (RST_CYC at least 5) present tms_o = 1 at the rising edge. This brings every device to Test-Logic-Reset from any state.
- R4: The instruction scan shifts MAX_DEV*IR_BITS ones, with tms_o high only on its final bit. After a probe of a chain of up to MAX_DEV devices, every device holds the all-ones (bypass) instruction.
- R5: For a chain of N bypassed devices with 1 <= N <= MAX_DEV, count_o equals N (unsigned binary) and error_o is 0.
- R6: If no 1 is seen on tdo_i within MAX_DEV test clocks after the marker, error_o is 1 and count_o is 0.
- R7: If tdo_i follows tdi_o directly (no device), the marker is seen at the rising edge on which it is sent, so count_o is 0 and error_o is 0.
- R8: A probe ends with every device in Run-Test/Idle and done_o high for exactly one system clock. count_o and error_o change only in that cycle.
- R9: start_i is ignored while a probe is running: a run still gives exactly one done pulse and no second probe follows.
- R10: tms_o and tdi_o change only at a falling edge of tck_o and stay stable while tck_o is high.
- R11: A probe lasts exactly RST_CYC + 5 + MAX_DEV*IR_BITS + 4 + MAX_DEV + (D+1) + 3 test clocks. D is the measured delay, or MAX_DEV when no marker returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a probe |
| tdo_i | input | 1 | Data returned from the last device of the chain |
| tck_o | output | 1 | Generated test clock |
| tms_o | output | 1 | Shared test mode select |
| tdi_o | output | 1 | Test data into the first device |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| count_o | output | $clog2(MAX_DEV+1) | Number of devices found |
| error_o | output | 1 | No marker returned within MAX_DEV test clocks |

## Verification
The probe is tried against modelled chains of random length between 1 and MAX_DEV. Each device starts in a random controller state with a random instruction, which shows whether the reset and bypass loading really bring every device into line. Directed chains of length 1 and MAX_DEV test both edges of the count. A direct wire (zero devices) tells the zero-delay case apart from a lost marker. A stuck-low return and a chain one longer than MAX_DEV must both give the error result and the longest run length. A start pulse in the middle of a run separates a correctly ignored request from one that restarts the sequence.

// File: rtl/tap_chain_pkg.sv
package tap_chain_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RESET,
      PH_TO_IR,
      PH_IR,
      PH_TO_DR,
      PH_FLUSH,
      PH_MEAS,
      PH_EXIT
   } phase_e;

   // mode-select walks, bit k is used on step k
   localparam logic [7:0] WALK_TO_IR = 8'b0000_0110;  // 0,1,1,0,0
   localparam logic [3:0] WALK_TO_DR = 4'b0011;       // 1,1,0,0
   localparam logic [3:0] WALK_EXIT  = 4'b0011;       // 1,1,0

   function automatic int unsigned max_of3(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/tap_tck_gen.sv
module tap_tck_gen #(
   parameter int unsigned CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tck_o,
   output logic rise_o,
   output logic fall_o
);
   localparam int unsigned HALF = CLK_DIV / 2;
   localparam int unsigned DW   = $clog2(CLK_DIV);

   logic [DW-1:0] div_q;

   // strobes mark the system edge on which tck changes
   assign rise_o = run_i && (div_q == DW'(HALF - 1));
   assign fall_o = run_i && (div_q == DW'(CLK_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         tck_o <= 1'b0;
      end else if (!run_i) begin
         div_q <= '0;
         tck_o <= 1'b0;
      end else begin
         div_q <= fall_o ? '0 : div_q + 1'b1;
         if (rise_o)      tck_o <= 1'b1;
         else if (fall_o) tck_o <= 1'b0;
      end
   end
endmodule

// File: rtl/tap_delay_meter.sv
module tap_delay_meter #(
   parameter int unsigned DLY_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             sample_i,
   input  logic             tdo_i,
   output logic             found_o,
   output logic [DLY_W-1:0] delay_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         found_o <= 1'b0;
         delay_o <= '0;
      end else if (clear_i) begin
         found_o <= 1'b0;
         delay_o <= '0;
      end else if (sample_i && !found_o) begin
         if (tdo_i) found_o <= 1'b1;
         else       delay_o <= delay_o + 1'b1;
      end
   end
endmodule

// File: rtl/tap_probe_seq.sv
module tap_probe_seq
   import tap_chain_pkg::*;
#(
   parameter int unsigned MAX_DEV = 32,
   parameter int unsigned IR_BITS = 4,
   parameter int unsigned RST_CYC = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic fall_i,
   input  logic found_i,
   output logic run_o,
   output logic tms_o,
   output logic tdi_o,
   output logic clear_o,
   output logic meas_o,
   output logic finish_o
);
   localparam int unsigned IR_LEN = MAX_DEV * IR_BITS;
   localparam int unsigned IW     = $clog2(max_of3(RST_CYC, IR_LEN, MAX_DEV + 1) + 1);

   phase_e        ph_q, ph_n;
   logic [IW-1:0] idx_q, idx_n;
   logic          last_step;

   function automatic logic [IW-1:0] phase_last(input phase_e p);
      case (p)
         PH_RESET: return IW'(RST_CYC - 1);
         PH_TO_IR: return IW'(4);
         PH_IR:    return IW'(IR_LEN - 1);
         PH_TO_DR: return IW'(3);
         PH_FLUSH: return IW'(MAX_DEV - 1);
         PH_MEAS:  return IW'(MAX_DEV);
         PH_EXIT:  return IW'(2);
         default:  return '0;
      endcase
   endfunction

   // {tms, tdi} presented during step i of phase p
   function automatic logic [1:0] phase_pins(input phase_e p, input logic [IW-1:0] i);
      case (p)
         PH_RESET: return 2'b10;
         PH_TO_IR: return {WALK_TO_IR[i[2:0]], 1'b0};
         PH_IR:    return {(i == IW'(IR_LEN - 1)), 1'b1};
         PH_TO_DR: return {WALK_TO_DR[i[1:0]], 1'b0};
         PH_FLUSH: return 2'b00;
         PH_MEAS:  return {1'b0, (i == '0)};
         PH_EXIT:  return {WALK_EXIT[i[1:0]], 1'b0};
         default:  return 2'b10;
      endcase
   endfunction

   always_comb begin
      ph_n      = ph_q;
      idx_n     = idx_q + 1'b1;
      last_step = (idx_q == phase_last(ph_q)) || ((ph_q == PH_MEAS) && found_i);
      if (last_step) begin
         idx_n = '0;
         case (ph_q)
            PH_RESET: ph_n = PH_TO_IR;
            PH_TO_IR: ph_n = PH_IR;
            PH_IR:    ph_n = PH_TO_DR;
            PH_TO_DR: ph_n = PH_FLUSH;
            PH_FLUSH: ph_n = PH_MEAS;
            PH_MEAS:  ph_n = PH_EXIT;
            default:  ph_n = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         idx_q <= '0;
         run_o <= 1'b0;
         tms_o <= 1'b1;
         tdi_o <= 1'b0;
      end else if (ph_q == PH_IDLE) begin
         if (start_i) begin
            ph_q           <= PH_RESET;
            idx_q          <= '0;
            run_o          <= 1'b1;
            {tms_o, tdi_o} <= phase_pins(PH_RESET, '0);
         end
      end else if (fall_i) begin
         ph_q  <= ph_n;
         idx_q <= idx_n;
         run_o <= (ph_n != PH_IDLE);
         if (ph_n != PH_IDLE) {tms_o, tdi_o} <= phase_pins(ph_n, idx_n);
      end
   end

   assign clear_o  = start_i && (ph_q == PH_IDLE);
   assign meas_o   = (ph_q == PH_MEAS);
   assign finish_o = fall_i && (ph_q == PH_EXIT) && last_step;
endmodule

// File: rtl/tap_chain_probe.sv
module tap_chain_probe
   import tap_chain_pkg::*;
#(
   parameter  int unsigned MAX_DEV = 32,
   parameter  int unsigned IR_BITS = 4,
   parameter  int unsigned RST_CYC = 5,
   parameter  int unsigned CLK_DIV = 4,
   localparam int unsigned CNT_W   = $clog2(MAX_DEV + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             tdo_i,
   output logic             tck_o,
   output logic             tms_o,
   output logic             tdi_o,
   output logic             done_o,
   output logic [CNT_W-1:0] count_o,
   output logic             error_o
);
   localparam int unsigned DLY_W = $clog2(MAX_DEV + 2);

   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("CLK_DIV must be even and at least 2");
   end
   if (MAX_DEV < 1) begin : g_bad_max
      $error("MAX_DEV must be at least 1");
   end
   if (IR_BITS < 2) begin : g_bad_ir
      $error("IR_BITS must be at least 2");
   end
   if (RST_CYC < 5) begin : g_bad_rst
      $error("RST_CYC must be at least 5");
   end

   logic             run, rise, fall;
   logic             clear, meas, finish;
   logic             found;
   logic [DLY_W-1:0] delay;

   tap_tck_gen #(.CLK_DIV(CLK_DIV)) u_tck (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .tck_o  (tck_o),
      .rise_o (rise),
      .fall_o (fall)
   );

   tap_probe_seq #(
      .MAX_DEV (MAX_DEV),
      .IR_BITS (IR_BITS),
      .RST_CYC (RST_CYC)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .fall_i   (fall),
      .found_i  (found),
      .run_o    (run),
      .tms_o    (tms_o),
      .tdi_o    (tdi_o),
      .clear_o  (clear),
      .meas_o   (meas),
      .finish_o (finish)
   );

   tap_delay_meter #(.DLY_W(DLY_W)) u_meter (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (clear),
      .sample_i (rise && meas),
      .tdo_i    (tdo_i),
      .found_o  (found),
      .delay_o  (delay)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o  <= 1'b0;
         count_o <= '0;
         error_o <= 1'b0;
      end else begin
         done_o <= finish;
         if (finish) begin
            error_o <= !found;
            count_o <= found ? CNT_W'(delay) : '0;
         end
      end
   end
endmodule

// File: rtl/tap_chain_probe_chk.sv
module tap_chain_probe_chk #(
   parameter int unsigned MAX_DEV = 32,
   parameter int unsigned CLK_DIV = 4,
   parameter int unsigned CNT_W   = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tck_o,
   input logic             tms_o,
   input logic             tdi_o,
   input logic             done_o,
   input logic [CNT_W-1:0] count_o,
   input logic             error_o
);
   localparam int unsigned HALF = CLK_DIV / 2;
   localparam int unsigned RW   = $clog2(CLK_DIV + 1);

   logic          tck_d;
   logic [RW-1:0] hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tck_d  <= 1'b0;
         hi_run <= '0;
      end else begin
         tck_d <= tck_o;
         if (tck_o && !tck_d)                       hi_run <= RW'(1);
         else if (tck_o && hi_run < RW'(CLK_DIV))   hi_run <= hi_run + 1'b1;
      end
   end

   assert_tck_high_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tck_o) |-> (hi_run == RW'(HALF)));

   assert_pins_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tck_o |=> (!tck_o || ($stable(tms_o) && $stable(tdi_o))));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_tck_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !tck_o);

   assert_result_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(count_o) || !$stable(error_o)) |-> done_o);

   assert_error_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      error_o |-> (count_o == '0));

   assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= CNT_W'(MAX_DEV));
endmodule

bind tap_chain_probe tap_chain_probe_chk #(
   .MAX_DEV (MAX_DEV),
   .CLK_DIV (CLK_DIV),
   .CNT_W   (CNT_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tck_o   (tck_o),
   .tms_o   (tms_o),
   .tdi_o   (tdi_o),
   .done_o  (done_o),
   .count_o (count_o),
   .error_o (error_o)
);

// File: tb/tap_chain_probe_bench.sv
module tap_chain_probe_bench;
   localparam int unsigned MAX_DEV = 32;
   localparam int unsigned IR_BITS = 4;
   localparam int unsigned RST_CYC = 5;
   localparam int unsigned CLK_DIV = 4;
   localparam int unsigned CNT_W   = $clog2(MAX_DEV + 1);
   localparam int          NDEV    = MAX_DEV + 1;

   // model controller states
   localparam logic [3:0] S_TLR = 4'd0,  S_RTI = 4'd1,  S_SDR = 4'd2,  S_CDR = 4'd3;
   localparam logic [3:0] S_SHD = 4'd4,  S_X1D = 4'd5,  S_PDR = 4'd6,  S_X2D = 4'd7;
   localparam logic [3:0] S_UDR = 4'd8,  S_SIR = 4'd9,  S_CIR = 4'd10, S_SHI = 4'd11;
   localparam logic [3:0] S_X1I = 4'd12, S_PIR = 4'd13, S_X2I = 4'd14, S_UIR = 4'd15;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tdo;
   logic tck, tms, tdi, done, err;
   logic [CNT_W-1:0] count;

   always #2.5 clk = ~clk;

   tap_chain_probe #(
      .MAX_DEV(MAX_DEV), .IR_BITS(IR_BITS), .RST_CYC(RST_CYC), .CLK_DIV(CLK_DIV)
   ) u_tap_chain_probe (
      .clk(clk), .rst_n(rst_n), .start_i(start), .tdo_i(tdo),
      .tck_o(tck), .tms_o(tms), .tdi_o(tdi), .done_o(done),
      .count_o(count), .error_o(err)
   );

   int checks = 0, errors = 0;
   int cyc = 0, done_seen = 0, rises = 0, last_rise = 0, tck_steps = 0;
   bit per_bad = 0, hold_bad = 0, pre_bad = 0, wd_fired = 0;
   logic tck_d = 1'b0, tms_d = 1'b1, tdi_d = 1'b0;
   int mode = 0, n_dev = 1;  // mode 0 chain, 1 direct wire, 2 stuck low

   logic [3:0]         st   [NDEV];
   logic [IR_BITS-1:0] ir   [NDEV];
   logic [IR_BITS-1:0] irsh [NDEV];
   logic               byp  [NDEV];
   logic [7:0]         dr   [NDEV];
   logic               dq   [NDEV];

   function automatic logic [3:0] nxt(input logic [3:0] s, input logic m);
      case (s)
         S_TLR: return m ? S_TLR : S_RTI;
         S_RTI: return m ? S_SDR : S_RTI;
         S_SDR: return m ? S_SIR : S_CDR;
         S_CDR: return m ? S_X1D : S_SHD;
         S_SHD: return m ? S_X1D : S_SHD;
         S_X1D: return m ? S_UDR : S_PDR;
         S_PDR: return m ? S_X2D : S_PDR;
         S_X2D: return m ? S_UDR : S_SHD;
         S_UDR: return m ? S_SDR : S_RTI;
         S_SIR: return m ? S_TLR : S_CIR;
         S_CIR: return m ? S_X1I : S_SHI;
         S_SHI: return m ? S_X1I : S_SHI;
         S_X1I: return m ? S_UIR : S_PIR;
         S_PIR: return m ? S_X2I : S_PIR;
         S_X2I: return m ? S_UIR : S_SHI;
         default: return m ? S_SDR : S_RTI;
      endcase
   endfunction

   // device models: act at rising test clock, drive output at falling
   always @(posedge tck) begin
      for (int i = 0; i < NDEV; i++) begin
         logic din;
         din = (i == 0) ? tdi : dq[i-1];
         case (st[i])
            S_TLR: ir[i] <= '0;
            S_CIR: irsh[i] <= IR_BITS'(1);
            S_SHI: irsh[i] <= {din, irsh[i][IR_BITS-1:1]};
            S_UIR: ir[i] <= irsh[i];
            S_CDR: if (&ir[i]) byp[i] <= 1'b0; else dr[i] <= 8'h00;
            S_SHD: if (&ir[i]) byp[i] <= din;  else dr[i] <= {din, dr[i][7:1]};
            default: ;
         endcase
         st[i] <= nxt(st[i], tms);
      end
      if (tck_steps < RST_CYC && !tms) pre_bad = 1'b1;
      tck_steps = tck_steps + 1;
   end

   always @(negedge tck) begin
      for (int i = 0; i < NDEV; i++) begin
         if (st[i] == S_SHI)      dq[i] <= irsh[i][0];
         else if (st[i] == S_SHD) dq[i] <= (&ir[i]) ? byp[i] : dr[i][0];
         else                     dq[i] <= 1'b0;
      end
   end

   always_comb begin
      if (mode == 2)       tdo = 1'b0;
      else if (mode == 1)  tdo = tdi;
      else if (n_dev == 0) tdo = tdi;
      else                 tdo = dq[n_dev-1];
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitors sample away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (done) done_seen++;
      if (tck && !tck_d) begin
         if (last_rise != 0 && (cyc - last_rise) != CLK_DIV) per_bad = 1'b1;
         last_rise = cyc;
         rises++;
      end
      if (tck && tck_d && (tms != tms_d || tdi != tdi_d)) hold_bad = 1'b1;
      tck_d = tck; tms_d = tms; tdi_d = tdi;
      if (cyc > 150000 && !wd_fired) begin
         wd_fired = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   function automatic int exp_count(input int md, input int n);
      return (md == 0 && n <= MAX_DEV) ? n : 0;
   endfunction

   function automatic int exp_error(input int md, input int n);
      return (md == 2 || (md == 0 && n > MAX_DEV)) ? 1 : 0;
   endfunction

   function automatic int exp_steps(input int md, input int n);
      int d;
      d = exp_error(md, n) ? MAX_DEV : exp_count(md, n);
      return RST_CYC + 5 + MAX_DEV * IR_BITS + 4 + MAX_DEV + (d + 1) + 3;
   endfunction

   task automatic run_probe(input int md, input int n, input bit mid_start);
      int d0, w, r0, bad_st, bad_ir;
      @(posedge clk);
      mode = md; n_dev = n;
      for (int i = 0; i < NDEV; i++) begin
         st[i]   = 4'($urandom);
         ir[i]   = IR_BITS'($urandom);
         irsh[i] = IR_BITS'($urandom);
         byp[i]  = 1'($urandom);
         dr[i]   = 8'($urandom);
         dq[i]   = 1'($urandom);
      end
      per_bad = 0; hold_bad = 0; pre_bad = 0; last_rise = 0; tck_steps = 0;
      d0 = done_seen;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      w = 0;
      while (done_seen == d0 && w < 20000) begin
         @(negedge clk);
         w++;
         start = (mid_start && w == 300);
      end
      start = 1'b0;
      @(negedge clk);
      check(int'(count) == exp_count(md, n), "R5/R7 count", int'(count), exp_count(md, n));
      check(int'(err) == exp_error(md, n), "R6 error flag", int'(err), exp_error(md, n));
      check(tck_steps == exp_steps(md, n), "R11 test clocks per run", tck_steps, exp_steps(md, n));
      check(!pre_bad, "R3 reset walk with tms high", int'(pre_bad), 0);
      check(!per_bad, "R2 tck period", int'(per_bad), 0);
      check(!hold_bad, "R10 tms/tdi stable while tck high", int'(hold_bad), 0);
      bad_st = 0; bad_ir = 0;
      for (int i = 0; i < NDEV; i++) begin
         if (st[i] != S_RTI) bad_st++;
         if (i < n && !(&ir[i])) bad_ir++;
      end
      check(bad_st == 0, "R8 devices left in Run-Test/Idle", bad_st, 0);
      if (md == 0 && n <= MAX_DEV)
         check(bad_ir == 0, "R4 devices holding bypass", bad_ir, 0);
      r0 = rises;
      repeat (60) @(negedge clk);
      check(done_seen == d0 + 1, mid_start ? "R9 start ignored while busy" : "R8 one done pulse",
            done_seen - d0, 1);
      check(rises == r0 && !tck, "R2 tck idle low", rises - r0, 0);
   endtask

   initial begin
      int seed;
      seed = $urandom(32'h1A2B3C);
      repeat (4) @(negedge clk);
      check(!tck && tms && !tdi && !done && count == '0 && !err, "R1 reset values",
            int'({tck, tms, tdi, done, err}), 8);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check(!tck && tms && !tdi && !done && count == '0 && !err, "R1 values after release",
            int'({tck, tms, tdi, done, err}), 8);
      run_probe(0, 1, 1'b0);            // R5 shortest chain
      run_probe(0, MAX_DEV, 1'b0);      // R5 longest chain
      run_probe(1, 0, 1'b0);            // R7 direct wire
      run_probe(2, 3, 1'b0);            // R6 stuck low
      run_probe(0, MAX_DEV + 1, 1'b0);  // R6 chain too long
      run_probe(0, 7, 1'b1);            // R9 start during run
      for (int k = 0; k < 8; k++) run_probe(0, 1 + int'($urandom_range(MAX_DEV - 1)), 1'b0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule